// File: doc/BRIEF.md
# Context-Based Page Translation Unit

This block turns a 24-bit virtual address from a 68000-class processor into a physical address, a two-bit bus type and a fault result. The processor function code selects one of two context registers. User codes use the user context and supervisor codes use the system context. The selected context and the low virtual page bits index a small page map held in flops. The map entry's five-bit protection code is decoded into separate supervisor and user rights. These rights are checked against the privilege and direction of the access. All translation results are combinational, so they are valid in the same cycle as the access inputs.

Accesses with function code 3 bypass the map and raise a control-space select for a neighbouring block. A boot-state input redirects supervisor program fetches to a read-only PROM window, while supervisor data accesses still translate. Software fills and inspects entries through a PTE port, which always addresses the map through the user context. A committed access that does not fault updates the referenced and modified bits of its entry.

The map holds 2^IDX_W pages per context. Virtual address bits above the indexed page field alias onto the same entries.

Top module: `ctx_page_xlate`

## Requirements
- R1: After reset, both context registers are 0 and every map entry reads as all zeros, so every translated access faults with `xl_fault_pv` low.
- R2: Function codes 1 and 2 index the map with the user context, and codes 5 and 6 index it with the system context. A context write through `ctx_user_we` or `ctx_sys_we` takes effect from the clock edge on which it is sampled.
- R3: Function code 3 raises `ctl_sel` and keeps `xl_hit` and `xl_fault` low, whatever the map holds.
- R4: Function codes 0, 4 and 7 leave `xl_hit`, `xl_fault` and `ctl_sel` all low.
- R5: A `pte_we` pulse stores `pte_wdata` into the entry at context `ctx_user` and page `pte_addr[14:11]`. `pte_rdata` shows that entry combinationally. The entry fields are:
  - bit 31: valid
  - bits 30:26: protection code
  - bit 25: fill-on-demand
  - bits 23:22: bus type (0 on-board memory, 1 on-board I/O, 2 bus memory, 3 bus I/O)
  - bit 21: referenced
  - bit 20: modified
  - bits 11:0: frame
- R6: A translated access returns `xl_paddr = {frame, va[10:0]}` and `xl_bus` equal to the entry's bus type.
- R7: An entry with bit 31 clear faults with `xl_fault_pv` low.
- R8: For a valid entry, the protection code grants the following rights, and any access those rights do not cover faults with `xl_fault_pv` high.
  - Supervisor read/write: 0x1F, 0x1E, 0x1D, 0x1C, 0x1B, 0x18.
  - Supervisor read-only: 0x17, 0x16, 0x14, 0x13, 0x10.
  - User read/write: 0x1F, 0x1B, 0x17, 0x13, 0x0F, 0x03.
  - User read-only: 0x1E, 0x16, 0x02.
  - Every other code grants nothing.
- R9: An entry of bus type 1 with frame 0 maps to the PROM. It returns `xl_paddr = PROM_BASE | va[14:0]` and `xl_bus = 0`.
- R10: With `boot_state` high, function code 6 ignores the map. A read hits with `xl_paddr = PROM_BASE | va[14:0]` and `xl_bus = 0`, and a write faults with `xl_fault_pv` high. Code 5 still translates through the map.
- R11: A committed access (`acc_valid`) that hits through the map sets the referenced bit (bit 21), and a write also sets the modified bit (bit 20), at the next clock edge. Faulting accesses and boot fetches change no entry. A `pte_we` to the same entry in the same cycle overrides the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_state | input | 1 | Boot state: supervisor program fetches go to PROM |
| ctx_user_we | input | 1 | Load user context register |
| ctx_user_wdata | input | 3 | New user context |
| ctx_sys_we | input | 1 | Load system context register |
| ctx_sys_wdata | input | 3 | New system context |
| acc_valid | input | 1 | Access commits this cycle (enables referenced/modified update) |
| acc_fc | input | 3 | Processor function code |
| acc_addr | input | 24 | Virtual address |
| acc_write | input | 1 | Access is a write |
| xl_hit | output | 1 | Translation succeeded |
| xl_fault | output | 1 | Access faults |
| xl_fault_pv | output | 1 | Fault occurred with a valid mapping (protection fault) |
| ctl_sel | output | 1 | Control-space access |
| xl_paddr | output | 23 | Physical address |
| xl_bus | output | 2 | Bus type of the physical address |
| pte_we | input | 1 | Write a map entry |
| pte_addr | input | 24 | Virtual address selecting the entry (user context) |
| pte_wdata | input | 32 | Entry value to write |
| pte_rdata | output | 32 | Entry at `pte_addr` in the user context |

## Verification
The translation outputs and `pte_rdata` depend combinationally on the inputs and map state. The bench therefore samples them 1 ns after it sets the inputs, inside the same low clock phase. Map writes, context loads and referenced/modified updates land at the next rising edge. The bench drives these on a falling edge and reads the result at the following falling edge, one cycle later. The context-load check probes before that edge and still expects the old context.

// File: rtl/ctx_page_xlate.sv
module ctx_page_xlate #(
  parameter int VA_W = 24,
  parameter int OFF_W = 11,
  parameter int IDX_W = 4,
  parameter int CTX_N = 8,
  parameter int FRAME_W = 12,
  parameter int PROM_W = 15,
  parameter int unsigned PROM_BASE = 'h7F8000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       boot_state,
  input  logic                       ctx_user_we,
  input  logic [$clog2(CTX_N)-1:0]   ctx_user_wdata,
  input  logic                       ctx_sys_we,
  input  logic [$clog2(CTX_N)-1:0]   ctx_sys_wdata,
  input  logic                       acc_valid,
  input  logic [2:0]                 acc_fc,
  input  logic [VA_W-1:0]            acc_addr,
  input  logic                       acc_write,
  output logic                       xl_hit,
  output logic                       xl_fault,
  output logic                       xl_fault_pv,
  output logic                       ctl_sel,
  output logic [FRAME_W+OFF_W-1:0]   xl_paddr,
  output logic [1:0]                 xl_bus,
  input  logic                       pte_we,
  input  logic [VA_W-1:0]            pte_addr,
  input  logic [31:0]                pte_wdata,
  output logic [31:0]                pte_rdata
);
  localparam int CTX_W = $clog2(CTX_N);
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int ENT   = CTX_N << IDX_W;
  localparam int ENT_W = CTX_W + IDX_W;

  logic [CTX_W-1:0] ctx_user, ctx_sys;
  logic [31:0]      pmap [ENT];

  // rights: {sup_wr, sup_rd, usr_wr, usr_rd}
  function automatic logic [3:0] rights(input logic [4:0] p);
    case (p)
      5'h1F, 5'h1B:        rights = 4'b1111;
      5'h1E:               rights = 4'b1101;
      5'h1C, 5'h1D, 5'h18: rights = 4'b1100;
      5'h16:               rights = 4'b0101;
      5'h17, 5'h13:        rights = 4'b0111;
      5'h14, 5'h10:        rights = 4'b0100;
      5'h0F, 5'h03:        rights = 4'b0011;
      5'h02:               rights = 4'b0001;
      default:             rights = 4'b0000;
    endcase
  endfunction

  wire is_user    = (acc_fc == 3'd1) || (acc_fc == 3'd2);
  wire is_sup     = (acc_fc == 3'd5) || (acc_fc == 3'd6);
  wire boot_fetch = boot_state && (acc_fc == 3'd6);
  wire translate  = (is_user || is_sup) && !boot_fetch;

  wire [CTX_W-1:0] ctx   = is_user ? ctx_user : ctx_sys;
  wire [ENT_W-1:0] a_idx = {ctx, acc_addr[OFF_W +: IDX_W]};
  wire [ENT_W-1:0] p_idx = {ctx_user, pte_addr[OFF_W +: IDX_W]};
  wire [31:0]      pte   = pmap[a_idx];

  wire [3:0]         rt      = rights(pte[30:26]);
  wire [1:0]         own     = is_user ? rt[1:0] : rt[3:2];
  wire               allowed = acc_write ? own[1] : own[0];
  wire [FRAME_W-1:0] frame   = pte[FRAME_W-1:0];
  wire               to_prom = boot_fetch || (pte[23:22] == 2'd1 && frame == '0);
  wire [PA_W-1:0]    prom_pa = PA_W'(PROM_BASE) | PA_W'(acc_addr[PROM_W-1:0]);

  assign ctl_sel     = (acc_fc == 3'd3);
  assign xl_hit      = translate ? (pte[31] && allowed) : (boot_fetch && !acc_write);
  assign xl_fault    = translate ? !(pte[31] && allowed) : (boot_fetch && acc_write);
  assign xl_fault_pv = translate ? (pte[31] && !allowed) : (boot_fetch && acc_write);
  assign xl_paddr    = to_prom ? prom_pa : {frame, acc_addr[OFF_W-1:0]};
  assign xl_bus      = to_prom ? 2'd0 : pte[23:22];
  assign pte_rdata   = pmap[p_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_user <= '0;
      ctx_sys  <= '0;
      for (int i = 0; i < ENT; i++) pmap[i] <= '0;
    end else begin
      if (ctx_user_we) ctx_user <= ctx_user_wdata;
      if (ctx_sys_we)  ctx_sys  <= ctx_sys_wdata;
      if (acc_valid && translate && pte[31] && allowed) begin
        pmap[a_idx][21] <= 1'b1;
        if (acc_write) pmap[a_idx][20] <= 1'b1;
      end
      if (pte_we) pmap[p_idx] <= pte_wdata;
    end
  end
endmodule

// File: rtl/ctx_page_xlate_chk.sv
module ctx_page_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boot_state,
  input logic        ctx_user_we,
  input logic [2:0]  acc_fc,
  input logic        acc_write,
  input logic        xl_hit,
  input logic        xl_fault,
  input logic        xl_fault_pv,
  input logic        ctl_sel,
  input logic [1:0]  xl_bus,
  input logic        pte_we,
  input logic [23:0] pte_addr,
  input logic [31:0] pte_wdata,
  input logic [31:0] pte_rdata
);
  p_ctl_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fc == 3'd3) |-> (ctl_sel && !xl_hit && !xl_fault));

  p_reserved_fc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fc == 3'd0 || acc_fc == 3'd4 || acc_fc == 3'd7) |-> !(xl_hit || xl_fault || ctl_sel));

  p_pv_needs_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_pv |-> (xl_fault && !xl_hit));

  p_boot_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state && acc_fc == 3'd6 && !acc_write) |-> (xl_hit && xl_bus == 2'd0));

  p_pte_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_we && !ctx_user_we) |=> ((pte_addr[14:11] != $past(pte_addr[14:11])) || pte_rdata == $past(pte_wdata)));
endmodule

bind ctx_page_xlate ctx_page_xlate_chk u_chk (.*);

// File: tb/ctx_page_xlate_tb.sv
module ctx_page_xlate_tb;
  logic        clk = 0, rst_n = 0, boot_state = 0;
  logic        ctx_user_we = 0, ctx_sys_we = 0;
  logic [2:0]  ctx_user_wdata = 0, ctx_sys_wdata = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [2:0]  acc_fc = 0;
  logic [23:0] acc_addr = 0;
  logic        xl_hit, xl_fault, xl_fault_pv, ctl_sel;
  logic [22:0] xl_paddr;
  logic [1:0]  xl_bus;
  logic        pte_we = 0;
  logic [23:0] pte_addr = 0;
  logic [31:0] pte_wdata = 0, pte_rdata;

  int tests = 0, fails = 0;
  localparam logic [22:0] PROM = 23'h7F8000;

  ctx_page_xlate u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pte_wr(input logic [23:0] va, input logic [31:0] d);
    @(negedge clk); pte_we = 1; pte_addr = va; pte_wdata = d;
    @(negedge clk); pte_we = 0;
  endtask

  task automatic set_ctx(input logic [2:0] u, input logic [2:0] s);
    @(negedge clk); ctx_user_we = 1; ctx_user_wdata = u; ctx_sys_we = 1; ctx_sys_wdata = s;
    @(negedge clk); ctx_user_we = 0; ctx_sys_we = 0;
  endtask

  task automatic probe(input logic [2:0] fc, input logic [23:0] va, input logic wr);
    @(negedge clk); acc_fc = fc; acc_addr = va; acc_write = wr; #1;
  endtask

  task automatic commit(input logic [2:0] fc, input logic [23:0] va, input logic wr);
    @(negedge clk); acc_fc = fc; acc_addr = va; acc_write = wr; acc_valid = 1;
    @(negedge clk); acc_valid = 0; #1;
  endtask

  function automatic logic [3:0] exp_rights(input logic [4:0] c);
    logic srw, sro, urw, uro;
    srw = c inside {5'h1F, 5'h1E, 5'h1D, 5'h1C, 5'h1B, 5'h18};
    sro = c inside {5'h17, 5'h16, 5'h14, 5'h13, 5'h10};
    urw = c inside {5'h1F, 5'h1B, 5'h17, 5'h13, 5'h0F, 5'h03};
    uro = c inside {5'h1E, 5'h16, 5'h02};
    return {srw, srw | sro, urw, urw | uro};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int p = 0; p < 16; p++) begin
      pte_addr = 24'(p << 11); #1;
      check(pte_rdata == 0, "R1 entry after reset", pte_rdata, 0);
    end
    probe(3'd1, 24'h001234, 0);
    check(xl_fault && !xl_fault_pv && !xl_hit, "R1 user fault after reset", {xl_hit, xl_fault, xl_fault_pv}, 3'b010);
    probe(3'd5, 24'h000800, 1);
    check(xl_fault && !xl_fault_pv, "R1 sup fault after reset", {xl_hit, xl_fault, xl_fault_pv}, 3'b010);

    // R8 protection sweep, R5 readback
    set_ctx(3, 3);
    for (int c = 0; c < 32; c++) begin
      logic [31:0] d;
      d = 32'h8000_0000 | (32'(c) << 26) | 32'h0A5;
      pte_wr(24'h002800, d);
      #1;
      check(pte_rdata == d, "R5 readback", pte_rdata, d);
      for (int f = 0; f < 4; f++) begin
        for (int w = 0; w < 2; w++) begin
          logic [2:0] fc;
          logic [3:0] r;
          logic ok_e;
          fc = (f == 0) ? 3'd1 : (f == 1) ? 3'd2 : (f == 2) ? 3'd5 : 3'd6;
          r = exp_rights(5'(c));
          ok_e = (f < 2) ? (w ? r[1] : r[0]) : (w ? r[3] : r[2]);
          probe(fc, 24'h002844, w[0]);
          check(xl_hit == ok_e && xl_fault == !ok_e && xl_fault_pv == !ok_e, "R8 protection",
                {c[7:0], fc, 1'(w), xl_hit, xl_fault, xl_fault_pv}, {c[7:0], fc, 1'(w), ok_e, !ok_e, !ok_e});
        end
      end
    end

    // R7 invalid entry
    pte_wr(24'h003000, 32'h7C00_0123);
    probe(3'd1, 24'h003010, 0);
    check(xl_fault && !xl_fault_pv && !xl_hit, "R7 invalid user", {xl_hit, xl_fault, xl_fault_pv}, 3'b010);
    probe(3'd6, 24'h003010, 1);
    check(xl_fault && !xl_fault_pv, "R7 invalid sup", {xl_hit, xl_fault, xl_fault_pv}, 3'b010);

    // R6 address and bus type sweep
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] fr;
        logic [10:0] off;
        logic [23:0] va;
        fr = (k == 0) ? 12'h001 : (k == 1) ? 12'h7FF : (k == 2) ? 12'hFFF : 12'h123;
        off = 11'(k * 517 + t * 3);
        va = (24'h5A << 15) | (24'd7 << 11) | 24'(off);
        pte_wr(va, 32'hFC00_0000 | (32'(t) << 22) | 32'(fr));
        probe(3'd2, va, 1);
        check(xl_hit && xl_paddr == {fr, off} && xl_bus == 2'(t), "R6 paddr/bus",
              {7'd0, xl_bus, xl_paddr}, {7'd0, 2'(t), fr, off});
      end
    end

    // R9 on-board I/O frame 0 maps to PROM
    pte_wr(24'h004800, 32'hFC40_0000);
    for (int k = 0; k < 4; k++) begin
      logic [23:0] va;
      va = 24'hA04800 | 24'(k * 123) | 24'(k << 12 & 24'h0000);
      probe(3'd1, va, 0);
      check(xl_hit && xl_paddr == (PROM | 23'(va[14:0])) && xl_bus == 0, "R9 prom page",
            {7'd0, xl_bus, xl_paddr}, {9'd0, PROM | 23'(va[14:0])});
    end

    // R2 context selection
    set_ctx(2, 0);
    pte_wr(24'h002000, 32'hFC00_0222);
    set_ctx(5, 2);
    pte_wr(24'h002000, 32'hFC00_0555);
    probe(3'd1, 24'h002001, 0);
    check(xl_paddr[22:11] == 12'h555, "R2 user ctx 5", xl_paddr, {12'h555, 11'h001});
    probe(3'd5, 24'h002001, 0);
    check(xl_paddr[22:11] == 12'h222, "R2 sys ctx 2", xl_paddr, {12'h222, 11'h001});
    set_ctx(2, 5);
    probe(3'd2, 24'h002001, 0);
    check(xl_paddr[22:11] == 12'h222, "R2 user ctx 2", xl_paddr, {12'h222, 11'h001});
    probe(3'd6, 24'h002001, 0);
    check(xl_paddr[22:11] == 12'h555, "R2 sys ctx 5", xl_paddr, {12'h555, 11'h001});
    @(negedge clk); ctx_user_we = 1; ctx_user_wdata = 5; acc_fc = 3'd1; #1;
    check(xl_paddr[22:11] == 12'h222, "R2 load not before edge", xl_paddr, {12'h222, 11'h001});
    @(negedge clk); ctx_user_we = 0; #1;
    check(xl_paddr[22:11] == 12'h555, "R2 load after edge", xl_paddr, {12'h555, 11'h001});

    // R3 control space, R4 reserved codes
    probe(3'd3, 24'h002001, 1);
    check(ctl_sel && !xl_hit && !xl_fault, "R3 control space", {ctl_sel, xl_hit, xl_fault}, 3'b100);
    for (int f = 0; f < 3; f++) begin
      logic [2:0] fc;
      fc = (f == 0) ? 3'd0 : (f == 1) ? 3'd4 : 3'd7;
      probe(fc, 24'h002001, 0);
      check(!ctl_sel && !xl_hit && !xl_fault, "R4 reserved fc", {fc, ctl_sel, xl_hit, xl_fault}, {fc, 3'b000});
    end

    // R10 boot state
    boot_state = 1;
    probe(3'd6, 24'hABCDEF, 0);
    check(xl_hit && !xl_fault && xl_paddr == 23'h7FCDEF && xl_bus == 0, "R10 boot fetch",
          {7'd0, xl_bus, xl_paddr}, {9'd0, 23'h7FCDEF});
    probe(3'd6, 24'hABCDEF, 1);
    check(xl_fault && xl_fault_pv && !xl_hit, "R10 boot fetch write", {xl_hit, xl_fault, xl_fault_pv}, 3'b011);
    probe(3'd5, 24'h002001, 0);
    check(xl_hit && xl_paddr[22:11] == 12'h555, "R10 boot data translates", xl_paddr, {12'h555, 11'h001});
    boot_state = 0;
    probe(3'd6, 24'hABCDEF, 0);
    check(xl_paddr[22:11] != PROM[22:11] || !xl_hit, "R10 off -> map", xl_paddr, 0);

    // R11 referenced / modified
    set_ctx(1, 1);
    pte_wr(24'h001000, 32'hFC00_00F0);
    pte_wr(24'h001800, 32'h8000_00F1);
    pte_addr = 24'h001000; #1;
    check(pte_rdata[21:20] == 2'b00, "R11 initial ref/mod", pte_rdata[21:20], 0);
    commit(3'd1, 24'h001004, 0);
    pte_addr = 24'h001000; #1;
    check(pte_rdata[21:20] == 2'b10, "R11 read sets ref", pte_rdata[21:20], 2);
    commit(3'd5, 24'h001004, 1);
    #1;
    check(pte_rdata[21:20] == 2'b11, "R11 write sets mod", pte_rdata[21:20], 3);
    commit(3'd1, 24'h001804, 1);
    pte_addr = 24'h001800; #1;
    check(pte_rdata == 32'h8000_00F1, "R11 fault no update", pte_rdata, 32'h8000_00F1);
    boot_state = 1;
    commit(3'd6, 24'h001804, 0);
    boot_state = 0; #1;
    check(pte_rdata == 32'h8000_00F1, "R11 boot fetch no update", pte_rdata, 32'h8000_00F1);
    @(negedge clk); acc_fc = 3'd1; acc_addr = 24'h001000; acc_write = 1; acc_valid = 1;
    pte_we = 1; pte_addr = 24'h001000; pte_wdata = 32'hFC00_0077;
    @(negedge clk); acc_valid = 0; pte_we = 0; #1;
    check(pte_rdata == 32'hFC00_0077, "R11 pte write wins", pte_rdata, 32'hFC00_0077);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule